// File: doc/BRIEF.md
# Object name hash lookup engine

This block turns a 32-bit object name plus a 7-bit channel id into the 32-bit context word stored for that pair. It searches a hash table of 8-byte records, each a name followed by its context word, held in an on-chip table RAM with a synchronous read port. The search starts at the record chosen by an 8-bit key. The key is the XOR of the four name bytes and the channel id. On a collision the search moves to the next record, wrapping inside the configured table size.

A request is offered with `req_valid` and taken when `req_ready` is high. Only one lookup is in flight at a time. Each record read takes two cycles: the read is issued, then the record is judged. The result comes back as a single-cycle `rsp_valid` pulse that carries the hit flag, the context word and the number of records read. Table base and size are sampled when the request is taken. A separate write port loads records directly into the table RAM.

Top module: `objhash_lookup`

## Requirements
- R1: While and after a synchronous active-low reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The key is the XOR of name bytes [31:24], [23:16], [15:8] and [7:0] with the channel id zero-extended to 8 bits. The first record read has table index `cfg_tbl_base*512 + key`, where one table record index is 8 bytes and the table RAM index is that value modulo the RAM depth.
- R3: A record is a hit when its stored name equals the requested name and bits [30:24] of its stored context equal the requested channel. The response then has `rsp_hit`=1, `rsp_context` equal to the stored context word and `rsp_probes` equal to the number of records read.
- R4: A record that is not empty and not a hit, including one with the right name but a different channel field, sends the search to the next record index.
- R5: A record whose stored name is zero is empty. Reading it ends the search as a miss with `rsp_hit`=0, `rsp_context`=0, and `rsp_probes` counting the empty record.
- R6: The search ends as a miss once `max_probes` records have been read without a hit. A `max_probes` value of 0 acts as 1.
- R7: A hit on the last record that the limit allows is reported as a hit, not as a miss.
- R8: The record index is `(key + n) mod (512 << cfg_tbl_size)` above the table base for the n-th record after the first. Table size codes 0, 1, 2 and 3 select 4, 8, 16 and 32 KB. The base code counts in 4 KB units.
- R9: `req_ready` is 1 only when idle. A request offered while busy is ignored. `rsp_valid` is a one-cycle pulse that rises exactly 2 x `rsp_probes` clock edges after the edge that took the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tbl_base | input | 4 | Table base in 4 KB units, sampled at request |
| cfg_tbl_size | input | 2 | Table size code (0: 4 KB, 1: 8 KB, 2: 16 KB, 3: 32 KB) |
| max_probes | input | 10 | Most records read per lookup (0 acts as 1) |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_name | input | 32 | Object name to resolve |
| req_chid | input | 7 | Channel id of the request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Matching record found |
| rsp_context | output | 32 | Stored context word on a hit, zero on a miss |
| rsp_probes | output | 10 | Records read for this lookup |
| wr_en | input | 1 | Table RAM record write strobe |
| wr_idx | input | 10 | Table RAM record index to write |
| wr_name | input | 32 | Name half of the written record |
| wr_ctx | input | 32 | Context half of the written record |

## Verification
Two terminating conditions can arrive on the same record read: a match is found, and the probe limit is reached. The bench provokes this by placing a record with the requested name and channel behind three occupied records. It then looks up that name with a limit of exactly four and again with a limit of three. The first lookup must report a hit with four probes. The second must report a miss with three probes, zero context and the matching latency.

// File: rtl/objhash_pkg.sv
`timescale 1ns/1ps
// objhash_pkg: shared constants, record type and key folding for the
// object name hash lookup engine. Assumes 8-byte records and 4 KB units.
package objhash_pkg;
    localparam int unsigned NAME_W       = 32;
    localparam int unsigned CTX_W        = 32;
    localparam int unsigned KEY_W        = 8;
    localparam int unsigned CFG_BASE_W   = 4;
    localparam int unsigned CFG_SIZE_W   = 2;
    localparam int unsigned CTX_CHID_LSB = 24;
    // records in one 4 KB unit, as a power of two (4096 / 8 = 512)
    localparam int unsigned UNIT_RECS_LG = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CHECK = 2'd2
    } lk_state_e;

    typedef struct packed {
        logic [NAME_W-1:0] name;
        logic [CTX_W-1:0]  ctx;
    } rec_t;

    // fold the four name bytes and the widened channel id into a key
    function automatic logic [KEY_W-1:0] fold_key(input logic [NAME_W-1:0] nm,
                                                  input logic [KEY_W-1:0]  ch);
        return nm[31:24] ^ nm[23:16] ^ nm[15:8] ^ nm[7:0] ^ ch;
    endfunction
endpackage

// File: rtl/objhash_addr.sv
`timescale 1ns/1ps
// objhash_addr: turns (name, channel, base, size code, probe number) into a
// table RAM record index. Purely combinational. Assumes the channel id is
// no wider than the key; the probe offset wraps inside the selected size.
module objhash_addr
    import objhash_pkg::*;
#(
    parameter int unsigned CHID_W  = 7,
    parameter int unsigned PROBE_W = 10,
    parameter int unsigned IDX_W   = 10
) (
    input  logic [NAME_W-1:0]     name_i,
    input  logic [CHID_W-1:0]     chid_i,
    input  logic [CFG_BASE_W-1:0] base_i,
    input  logic [CFG_SIZE_W-1:0] size_i,
    input  logic [PROBE_W-1:0]    probe_i,
    output logic [IDX_W-1:0]      rec_idx_o
);
    logic [KEY_W-1:0] key_w;
    logic [31:0]      sum_w;
    logic [31:0]      mask_w;
    logic [31:0]      rel_w;

    // home key plus probe offset, masked to the table size, above the base
    always_comb begin
        key_w     = fold_key(name_i, KEY_W'(chid_i));
        sum_w     = 32'(key_w) + 32'(probe_i);
        mask_w    = (32'(1) << (UNIT_RECS_LG + 32'(size_i))) - 32'(1);
        rel_w     = sum_w & mask_w;
        rec_idx_o = IDX_W'((32'(base_i) << UNIT_RECS_LG) + rel_w);
    end
endmodule

// File: rtl/objhash_ram.sv
`timescale 1ns/1ps
// objhash_ram: record store with one write port and one synchronous read
// port (one-cycle latency). A read and a write to the same index in one
// cycle return the record as it was before the write.
module objhash_ram
    import objhash_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rec_t             wr_rec,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output rec_t             rd_rec
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    rec_t mem [DEPTH];

    // record write from the load port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_rec;
        end
    end

    // registered record read
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_rec <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/objhash_ctrl.sv
`timescale 1ns/1ps
// objhash_ctrl: takes one request, steps through records two cycles each
// (issue read, judge record) and ends on hit, empty record or probe limit.
// Assumes the record on rd_rec belongs to the index issued one cycle earlier.
module objhash_ctrl
    import objhash_pkg::*;
#(
    parameter int unsigned CHID_W  = 7,
    parameter int unsigned PROBE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_BASE_W-1:0] cfg_tbl_base,
    input  logic [CFG_SIZE_W-1:0] cfg_tbl_size,
    input  logic [PROBE_W-1:0]    max_probes,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [NAME_W-1:0]     req_name,
    input  logic [CHID_W-1:0]     req_chid,
    input  rec_t                  rd_rec,
    output logic                  rd_en,
    output logic [NAME_W-1:0]     cur_name,
    output logic [CHID_W-1:0]     cur_chid,
    output logic [CFG_BASE_W-1:0] cur_base,
    output logic [CFG_SIZE_W-1:0] cur_size,
    output logic [PROBE_W-1:0]    cur_probe,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [CTX_W-1:0]      rsp_context,
    output logic [PROBE_W-1:0]    rsp_probes
);
    localparam int unsigned PW1 = PROBE_W + 1;

    lk_state_e          state_q;
    logic [PROBE_W-1:0] lim_q;
    logic [PROBE_W-1:0] lim_in;
    logic [PW1-1:0]     read_cnt;
    logic               rec_empty;
    logic               rec_match;
    logic               rec_last;

    // decode of the judged record and of the limit to latch
    always_comb begin
        lim_in    = (max_probes == '0) ? PROBE_W'(1) : max_probes;
        read_cnt  = {1'b0, cur_probe} + PW1'(1);
        rec_empty = (rd_rec.name == '0);
        rec_match = (rd_rec.name == cur_name) &&
                    (rd_rec.ctx[CTX_CHID_LSB +: CHID_W] == cur_chid);
        rec_last  = (read_cnt >= {1'b0, lim_q});
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rd_en     = (state_q == ST_ISSUE);

    // lookup sequencing, request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lim_q       <= PROBE_W'(1);
            cur_name    <= '0;
            cur_chid    <= '0;
            cur_base    <= '0;
            cur_size    <= '0;
            cur_probe   <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_context <= '0;
            rsp_probes  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_name  <= req_name;
                        cur_chid  <= req_chid;
                        cur_base  <= cfg_tbl_base;
                        cur_size  <= cfg_tbl_size;
                        lim_q     <= lim_in;
                        cur_probe <= '0;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (rec_empty || rec_match || rec_last) begin
                        rsp_valid   <= 1'b1;
                        rsp_hit     <= rec_match && !rec_empty;
                        rsp_context <= (rec_match && !rec_empty) ? rd_rec.ctx : '0;
                        rsp_probes  <= read_cnt[PROBE_W-1:0];
                        state_q     <= ST_IDLE;
                    end else begin
                        cur_probe <= read_cnt[PROBE_W-1:0];
                        state_q   <= ST_ISSUE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    probe_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_probes <= lim_q) && (rsp_probes != '0)));

    // R5
    miss_context_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_context == '0));

    // R3
    hit_channel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_context[CTX_CHID_LSB +: CHID_W] == cur_chid));
endmodule

// File: rtl/objhash_lookup.sv
`timescale 1ns/1ps
// objhash_lookup: top of the object name hash lookup engine. Connects the
// sequencer, the record address generator and the table RAM. Assumes the
// load port is used only while no lookup depends on the records it changes.
module objhash_lookup
    import objhash_pkg::*;
#(
    parameter int unsigned CHID_W    = 7,
    parameter int unsigned PROBE_W   = 10,
    parameter int unsigned RAM_IDX_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_BASE_W-1:0] cfg_tbl_base,
    input  logic [CFG_SIZE_W-1:0] cfg_tbl_size,
    input  logic [PROBE_W-1:0]    max_probes,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [NAME_W-1:0]     req_name,
    input  logic [CHID_W-1:0]     req_chid,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [CTX_W-1:0]      rsp_context,
    output logic [PROBE_W-1:0]    rsp_probes,
    input  logic                  wr_en,
    input  logic [RAM_IDX_W-1:0]  wr_idx,
    input  logic [NAME_W-1:0]     wr_name,
    input  logic [CTX_W-1:0]      wr_ctx
);
    rec_t                  rd_rec;
    rec_t                  wr_rec;
    logic                  rd_en;
    logic [RAM_IDX_W-1:0]  rd_idx;
    logic [NAME_W-1:0]     cur_name;
    logic [CHID_W-1:0]     cur_chid;
    logic [CFG_BASE_W-1:0] cur_base;
    logic [CFG_SIZE_W-1:0] cur_size;
    logic [PROBE_W-1:0]    cur_probe;

    // pack the load port into one record
    always_comb begin
        wr_rec.name = wr_name;
        wr_rec.ctx  = wr_ctx;
    end

    objhash_ctrl #(
        .CHID_W  (CHID_W),
        .PROBE_W (PROBE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_tbl_base (cfg_tbl_base),
        .cfg_tbl_size (cfg_tbl_size),
        .max_probes   (max_probes),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_name     (req_name),
        .req_chid     (req_chid),
        .rd_rec       (rd_rec),
        .rd_en        (rd_en),
        .cur_name     (cur_name),
        .cur_chid     (cur_chid),
        .cur_base     (cur_base),
        .cur_size     (cur_size),
        .cur_probe    (cur_probe),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_context  (rsp_context),
        .rsp_probes   (rsp_probes)
    );

    objhash_addr #(
        .CHID_W  (CHID_W),
        .PROBE_W (PROBE_W),
        .IDX_W   (RAM_IDX_W)
    ) u_addr (
        .name_i    (cur_name),
        .chid_i    (cur_chid),
        .base_i    (cur_base),
        .size_i    (cur_size),
        .probe_i   (cur_probe),
        .rec_idx_o (rd_idx)
    );

    objhash_ram #(
        .IDX_W (RAM_IDX_W)
    ) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_rec (wr_rec),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .rd_rec (rd_rec)
    );
endmodule

// File: tb/objhash_lookup_test.sv
`timescale 1ns/1ps
// objhash_lookup_test: directed corner cases plus seeded random lookups,
// compared against a shadow table and a bench search model.
module objhash_lookup_test;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_tbl_base = '0;
    logic [1:0]  cfg_tbl_size = '0;
    logic [9:0]  max_probes = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_name = '0;
    logic [6:0]  req_chid = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_context;
    logic [9:0]  rsp_probes;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_idx = '0;
    logic [31:0] wr_name = '0;
    logic [31:0] wr_ctx = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] mdl [DEPTH];
    logic [31:0] ins_n [64];
    logic [6:0]  ins_c [64];

    always #2.5 clk = ~clk;

    objhash_lookup uut (
        .clk(clk), .rst_n(rst_n), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_size(cfg_tbl_size),
        .max_probes(max_probes), .req_valid(req_valid), .req_ready(req_ready),
        .req_name(req_name), .req_chid(req_chid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_context(rsp_context), .rsp_probes(rsp_probes), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_name(wr_name), .wr_ctx(wr_ctx)
    );

    function automatic logic [7:0] bkey(input logic [31:0] n, input logic [6:0] c);
        logic [7:0] k = {1'b0, c};
        for (int b = 0; b < 4; b++) k = k ^ n[8*b +: 8];
        return k;
    endfunction

    function automatic int bidx(input logic [31:0] n, input logic [6:0] c,
                                input int base, input int size, input int p);
        int rel = (int'(bkey(n, c)) + p) % (512 << size);
        return (base * 512 + rel) % DEPTH;
    endfunction

    function automatic void mlook(input logic [31:0] n, input logic [6:0] c,
                                  input int base, input int size, input int maxp,
                                  output logic hit, output logic [31:0] ctx, output int probes);
        int lim = (maxp == 0) ? 1 : maxp;
        hit = 1'b0; ctx = '0; probes = 0;
        for (int p = 0; p < 1024; p++) begin
            logic [63:0] r = mdl[bidx(n, c, base, size, p)];
            probes = p + 1;
            if (r[63:32] == 32'd0) return;
            if (r[63:32] == n && r[30:24] == c) begin
                hit = 1'b1; ctx = r[31:0]; return;
            end
            if (p + 1 >= lim) return;
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] n, input logic [31:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[9:0]; wr_name = n; wr_ctx = c;
        @(posedge clk); #1;
        wr_en = 1'b0;
        mdl[idx] = {n, c};
    endtask

    task automatic clear_all();
        for (int i = 0; i < DEPTH; i++) wr(i, 32'd0, 32'd0);
    endtask

    task automatic lookup(input logic [31:0] n, input logic [6:0] c, input int base,
                          input int size, input int maxp, output logic hit,
                          output logic [31:0] ctx, output int probes, output int cyc);
        @(negedge clk);
        cfg_tbl_base = base[3:0]; cfg_tbl_size = size[1:0]; max_probes = maxp[9:0];
        req_name = n; req_chid = c; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        cyc = 0; hit = 1'b0; ctx = '0; probes = 0;
        while (1) begin
            @(posedge clk); #1;
            cyc++;
            if (rsp_valid) begin
                hit = rsp_hit; ctx = rsp_context; probes = int'(rsp_probes);
                break;
            end
            if (cyc > 4000) begin
                chk("R9 watchdog: no response", 32'd0, 32'd1);
                break;
            end
        end
    endtask

    task automatic expect_lk(input string tag, input logic [31:0] n, input logic [6:0] c,
                             input int base, input int size, input int maxp,
                             input logic eh, input logic [31:0] ectx, input int ep);
        logic hit; logic [31:0] ctx; int probes; int cyc;
        lookup(n, c, base, size, maxp, hit, ctx, probes, cyc);
        chk({tag, " hit"}, 32'(hit), 32'(eh));
        chk({tag, " context"}, ctx, ectx);
        chk({tag, " probes"}, probes, ep);
        chk({tag, " R9 latency"}, cyc, 2 * ep);
        @(posedge clk); #1;
        chk({tag, " R9 pulse"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic expect_model(input string tag, input logic [31:0] n, input logic [6:0] c,
                                input int base, input int size, input int maxp);
        logic eh; logic [31:0] ectx; int ep;
        mlook(n, c, base, size, maxp, eh, ectx, ep);
        expect_lk(tag, n, c, base, size, maxp, eh, ectx, ep);
    endtask

    task automatic insert(input logic [31:0] n, input logic [6:0] c, input int base, input int size);
        int p = 0;
        while (mdl[bidx(n, c, base, size, p)][63:32] != 32'd0 && p < 1023) p++;
        wr(bidx(n, c, base, size, p), n, {1'b0, c, 8'($urandom), 16'($urandom)});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

        clear_all();

        // R2/R3: key 0x41 for name 0x11223344 channel 5, found at its home record
        chk("R2 bench key", 32'(bkey(32'h11223344, 7'd5)), 32'h41);
        wr(32'h41, 32'h11223344, 32'h05C71234);
        expect_lk("R2 R3 home hit", 32'h11223344, 7'd5, 0, 0, 8, 1'b1, 32'h05C71234, 1);

        // R4: same key, next record
        wr(32'h42, 32'h00000041, 32'h00801111);
        expect_lk("R4 collision", 32'h00000041, 7'd0, 0, 0, 8, 1'b1, 32'h00801111, 2);

        // R4: same name, wrong channel field, is skipped
        wr(32'h43, 32'h11223340, 32'h02000000);
        wr(32'h44, 32'h11223340, 32'h01000077);
        expect_lk("R4 channel mismatch skip", 32'h11223340, 7'd1, 0, 0, 8, 1'b1, 32'h01000077, 4);

        // R5: empty record ends the search
        expect_lk("R5 empty miss", 32'h00000140, 7'd0, 0, 0, 8, 1'b0, 32'd0, 5);

        // R6: probe limit, and limit 0 acting as 1
        expect_lk("R6 limit 3", 32'h00000140, 7'd0, 0, 0, 3, 1'b0, 32'd0, 3);
        expect_lk("R6 limit 0", 32'h00000140, 7'd0, 0, 0, 0, 1'b0, 32'd0, 1);

        // R7: hit and limit on the same record read
        expect_lk("R7 hit on last probe", 32'h11223340, 7'd1, 0, 0, 4, 1'b1, 32'h01000077, 4);
        expect_lk("R7 limit one short", 32'h11223340, 7'd1, 0, 0, 3, 1'b0, 32'd0, 3);

        // R8: wrap inside a 4 KB table, not inside an 8 KB table
        for (int i = 255; i < 512; i++) wr(i, 32'hABCD0000 + i, 32'd0);
        wr(0, 32'h000000FF, 32'h00400000);
        expect_lk("R8 wrap size0", 32'h000000FF, 7'd0, 0, 0, 1023, 1'b1, 32'h00400000, 258);
        expect_lk("R8 no wrap size1", 32'h000000FF, 7'd0, 0, 1, 1023, 1'b0, 32'd0, 258);

        // R2/R8: base selects a different 4 KB unit
        expect_lk("R8 base1 empty", 32'h11223344, 7'd5, 1, 0, 8, 1'b0, 32'd0, 1);
        wr(512 + 32'h41, 32'h11223344, 32'h05000099);
        expect_lk("R2 base1 hit", 32'h11223344, 7'd5, 1, 0, 8, 1'b1, 32'h05000099, 1);

        // R9: request offered while busy is ignored
        begin
            int cyc = 0;
            @(negedge clk);
            cfg_tbl_base = 4'd0; cfg_tbl_size = 2'd0; max_probes = 10'd8;
            req_name = 32'h11223344; req_chid = 7'd5; req_valid = 1'b1;
            @(posedge clk); #1;
            req_name = 32'h00000041; req_chid = 7'd0;
            chk("R9 not ready while busy", 32'(req_ready), 32'd0);
            while (cyc < 100) begin
                @(posedge clk); #1;
                cyc++;
                if (rsp_valid) break;
            end
            req_valid = 1'b0;
            chk("R9 busy request ignored ctx", rsp_context, 32'h05C71234);
            chk("R9 busy latency", cyc, 2);
            for (int k = 0; k < 5; k++) begin
                @(posedge clk); #1;
                chk("R9 no second response", 32'(rsp_valid), 32'd0);
            end
            chk("R9 ready when idle", 32'(req_ready), 32'd1);
        end

        // random phase: R3/R4/R5/R6/R8 against the model
        clear_all();
        begin
            int base = int'($urandom_range(0, 1));
            int size = int'($urandom_range(0, 1));
            for (int i = 0; i < 32; i += 2) begin
                logic [31:0] n = $urandom | 32'h1;
                logic [6:0]  c = 7'($urandom);
                ins_n[i] = n; ins_c[i] = c;
                ins_n[i+1] = n ^ 32'h01010000; ins_c[i+1] = c;
                insert(ins_n[i], c, base, size);
                insert(ins_n[i+1], c, base, size);
            end
            for (int t = 0; t < 60; t++) begin
                int j = int'($urandom_range(0, 31));
                int maxp = int'($urandom_range(0, 6));
                if (t % 3 == 2)
                    expect_model("R5 R6 random absent", $urandom | 32'h100, 7'($urandom), base, size, maxp);
                else if (t % 3 == 1)
                    expect_model("R4 random wrong channel", ins_n[j], ins_c[j] ^ 7'h11, base, size, maxp);
                else
                    expect_model("R3 R4 random present", ins_n[j], ins_c[j], base, size, maxp);
            end
        end

        summary();
        $finish;
    end
endmodule